// File: doc/BRIEF.md
# Dual-Clock Bidirectional Word Buffer with Mailboxes

This block joins a processor-side word port to a peripheral-side word port. The two ports run on unrelated clocks, and the peripheral clock may be periodic, irregular or bursty at up to 100 MHz. Each direction has its own FIFO with a 32-bit data path. The inbound FIFO carries data from the peripheral to the processor. The outbound FIFO carries data from the processor to the peripheral.

On the peripheral side, one shared data bus is split into an input half and an output half with an output enable. A transfer happens only on a peripheral clock edge with chip select high. The direction pin picks which FIFO is used: high pushes into the inbound FIFO, low pops from the outbound FIFO. With the mailbox select high instead, a write goes to one of two mailbox registers rather than to a FIFO, and raises a processor interrupt.

Each side of each FIFO keeps registered full, almost-full, almost-empty and empty flags in its own clock domain. The thresholds come from two programmable levels. The pointers cross between the domains as Gray codes through two-stage synchronizers, so a flag may be late but never reports room or data that does not exist. An asynchronous clear input empties both FIFOs and leaves the mailboxes unchanged.

Top module: `bififo_mbx`

## Requirements
- R1: Words pushed at the peripheral port (per_cs=1, per_dir=1, per_mbsel=0 on a per_clk rising edge) appear on cpu_rdata in push order. The head word is shown before cpu_rd pops it.
- R2: Words pushed with cpu_wr are read in order on per_dout. A pop happens on a per_clk edge with per_cs=1, per_dir=0, per_mbsel=0, and per_oe is high exactly while per_cs=1, per_dir=0 and per_mbsel=0.
- R3: A push into a full FIFO or a pop from an empty FIFO is ignored: no word is stored and no pointer moves. With the default depth, the FIFO holds 16 words.
- R4: While per_cs=0, no transfer happens on either FIFO, whatever per_dir and per_din are doing.
- R5: On the peripheral side, the inbound flags use the fill level L. per_in_full is high when L equals the depth. per_in_afull is high when L >= cfg_afull. per_in_aempty is high when L <= cfg_aempty. After a peripheral push these flags are valid at the next per_clk edge.
- R6: On the peripheral side, the outbound flags use the level L. per_out_empty is high when L is 0. per_out_aempty is high when L <= cfg_aempty. per_out_afull is high when L >= cfg_afull. After a peripheral pop these flags are valid at the next per_clk edge.
- R7: On the processor side, the flags cpu_in_empty, cpu_in_afull, cpu_in_aempty, cpu_out_full, cpu_out_afull and cpu_out_aempty follow the same rules. cpu_irq is the OR of the mailbox interrupts with (irq_en[0] AND cpu_in_afull) and (irq_en[1] AND cpu_out_aempty).
- R8: Asserting per_fifo_clr empties both FIFOs. After the clear the empty and almost-empty flags are high, the full and almost-full flags are low, and the mailbox contents and interrupts are unchanged.
- R9: A peripheral write with per_cs=1, per_dir=1, per_mbsel=1 stores per_din in mailbox per_mbidx, leaves both FIFOs untouched, and sets mb_irq[per_mbidx] once the write has crossed into the processor clock domain.
- R10: A processor read (cpu_mb_rd=1) shows the word of mailbox cpu_mb_idx on cpu_mb_data. The read clears only mb_irq[cpu_mb_idx]; the other mailbox's interrupt is kept.
- R11: If a mailbox write arrives in the processor domain in the same cycle that the processor reads that mailbox, the interrupt is set. The new message is not lost.
- R12: After rst_n, both FIFOs are empty, per_oe is low and mb_irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Global asynchronous reset, active low |
| per_clk | input | 1 | Peripheral port clock |
| per_fifo_clr | input | 1 | Asynchronous clear of both FIFOs, active high |
| per_cs | input | 1 | Peripheral chip select |
| per_dir | input | 1 | 1 = push into inbound FIFO or mailbox, 0 = pop from outbound FIFO |
| per_mbsel | input | 1 | Selects the mailboxes in place of the FIFOs |
| per_mbidx | input | 1 | Mailbox index for a peripheral mailbox write |
| per_din | input | 32 | Peripheral bus, input half |
| per_dout | output | 32 | Peripheral bus, output half (outbound head word) |
| per_oe | output | 1 | Output enable for the peripheral bus |
| per_in_full | output | 1 | Inbound full, peripheral domain |
| per_in_afull | output | 1 | Inbound almost full, peripheral domain |
| per_in_aempty | output | 1 | Inbound almost empty, peripheral domain |
| per_out_empty | output | 1 | Outbound empty, peripheral domain |
| per_out_aempty | output | 1 | Outbound almost empty, peripheral domain |
| per_out_afull | output | 1 | Outbound almost full, peripheral domain |
| cpu_clk | input | 1 | Processor port clock |
| cfg_afull | input | 5 | Almost-full level, 1 to depth, held steady while in use |
| cfg_aempty | input | 5 | Almost-empty level, held steady while in use |
| cpu_wr | input | 1 | Push cpu_wdata into the outbound FIFO |
| cpu_wdata | input | 32 | Outbound write word |
| cpu_out_full | output | 1 | Outbound full, processor domain |
| cpu_out_afull | output | 1 | Outbound almost full, processor domain |
| cpu_out_aempty | output | 1 | Outbound almost empty, processor domain |
| cpu_rd | input | 1 | Pop the inbound head word |
| cpu_rdata | output | 32 | Inbound head word |
| cpu_in_empty | output | 1 | Inbound empty, processor domain |
| cpu_in_afull | output | 1 | Inbound almost full, processor domain |
| cpu_in_aempty | output | 1 | Inbound almost empty, processor domain |
| irq_en | input | 2 | Flag interrupt enables: bit 0 inbound almost full, bit 1 outbound almost empty |
| cpu_mb_rd | input | 1 | Mailbox read strobe, clears that mailbox's interrupt |
| cpu_mb_idx | input | 1 | Mailbox index for processor read |
| cpu_mb_data | output | 32 | Word of the selected mailbox |
| mb_irq | output | 2 | Per-mailbox interrupt |
| cpu_irq | output | 1 | Combined processor interrupt |

## Verification
The case that needs care is a mailbox message arriving in the processor domain in the same cycle that the processor reads that mailbox. Here a set and a clear of the same interrupt bit meet in one cycle. The bench provokes it by holding the read strobe high on mailbox 0 the whole time a peripheral write to that mailbox crosses the clock boundary, so the arrival cycle is covered without knowing its exact timing. A monitor sampling on the falling processor edge must see mb_irq[0] high for at least one cycle. After the strobe drops, the bit must be low and the mailbox must hold the new word; a design in which the clear wins never shows the pulse.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int PTR_W = 16;
  typedef logic [PTR_W-1:0] pw_t;

  typedef struct packed {
    logic full;
    logic afull;
    logic aempty;
  } wside_t;

  typedef struct packed {
    logic empty;
    logic aempty;
    logic afull;
  } rside_t;

  localparam wside_t WSIDE_RST = '{full: 1'b0, afull: 1'b0, aempty: 1'b1};
  localparam rside_t RSIDE_RST = '{empty: 1'b1, aempty: 1'b1, afull: 1'b0};

  function automatic pw_t to_gray(pw_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic pw_t from_gray(pw_t g);
    pw_t b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // flags seen by the pushing side, from the level it will hold next cycle
  function automatic wside_t wside_eval(pw_t lvl, pw_t af, pw_t ae, pw_t depth);
    wside_t f;
    f.full   = (lvl >= depth);
    f.afull  = (lvl >= af);
    f.aempty = (lvl <= ae);
    return f;
  endfunction

  // flags seen by the popping side
  function automatic rside_t rside_eval(pw_t lvl, pw_t af, pw_t ae);
    rside_t f;
    f.empty  = (lvl == '0);
    f.aempty = (lvl <= ae);
    f.afull  = (lvl >= af);
    return f;
  endfunction
endpackage

// File: rtl/bf_rst_sync.sv
module bf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta   <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta   <= 1'b1;
      srst_n <= meta;
    end
  end
endmodule

// File: rtl/bf_gray_sync.sv
module bf_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/bf_async_fifo.sv
module bf_async_fifo
  import bf_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  input  logic [AW:0]   lvl_af,
  input  logic [AW:0]   lvl_ae,
  output wside_t        wflg,
  output rside_t        rflg,
  output logic [AW:0]   wptr_o,
  output logic [AW:0]   rptr_o
);
  localparam int DEPTH = 1 << AW;
  typedef logic [AW:0] ptr_t;

  logic [DW-1:0] mem [DEPTH];
  ptr_t wbin, wgray, wbin_nx, rgray_w, rbin_w, wlvl_nx;
  ptr_t rbin, rgray, rbin_nx, wgray_r, wbin_r, rlvl_nx;
  logic wr_go, rd_go;

  // push side
  assign wr_go   = wr_en && !wflg.full;
  assign wbin_nx = wbin + ptr_t'(wr_go);

  bf_gray_sync #(.W(AW + 1)) u_rp_sync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w)
  );
  assign rbin_w  = ptr_t'(from_gray(PTR_W'(rgray_w)));
  assign wlvl_nx = wbin_nx - rbin_w;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      wflg  <= WSIDE_RST;
    end else begin
      wbin  <= wbin_nx;
      wgray <= ptr_t'(to_gray(PTR_W'(wbin_nx)));
      wflg  <= wside_eval(PTR_W'(wlvl_nx), PTR_W'(lvl_af), PTR_W'(lvl_ae),
                          PTR_W'(DEPTH));
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin[AW-1:0]] <= wdata;
  end

  // pop side
  assign rd_go   = rd_en && !rflg.empty;
  assign rbin_nx = rbin + ptr_t'(rd_go);

  bf_gray_sync #(.W(AW + 1)) u_wp_sync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r)
  );
  assign wbin_r  = ptr_t'(from_gray(PTR_W'(wgray_r)));
  assign rlvl_nx = wbin_r - rbin_nx;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      rflg  <= RSIDE_RST;
    end else begin
      rbin  <= rbin_nx;
      rgray <= ptr_t'(to_gray(PTR_W'(rbin_nx)));
      rflg  <= rside_eval(PTR_W'(rlvl_nx), PTR_W'(lvl_af), PTR_W'(lvl_ae));
    end
  end

  assign rdata  = mem[rbin[AW-1:0]];
  assign wptr_o = wbin;
  assign rptr_o = rbin;
endmodule

// File: rtl/bf_mbox.sv
module bf_mbox #(
  parameter int DW  = 32,
  parameter int NMB = 2,
  parameter int MIW = 1
) (
  input  logic           pclk,
  input  logic           prst_n,
  input  logic           wr_en,
  input  logic [MIW-1:0] wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic           cclk,
  input  logic           crst_n,
  input  logic           rd_en,
  input  logic [MIW-1:0] rd_idx,
  output logic [DW-1:0]  rd_data,
  output logic [NMB-1:0] irq,
  output logic [NMB-1:0] arrive
);
  logic [DW-1:0] box [NMB];

  for (genvar g = 0; g < NMB; g++) begin : g_box
    logic [DW-1:0] word_q;
    logic          tog_q, tog_s, tog_d, irq_q, clr_here;

    // peripheral domain: hold the word, flip a toggle per message
    always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
        word_q <= '0;
        tog_q  <= 1'b0;
      end else if (wr_en && wr_idx == MIW'(g)) begin
        word_q <= wr_data;
        tog_q  <= ~tog_q;
      end
    end

    bf_gray_sync #(.W(1)) u_tog_sync (
      .clk(cclk), .rst_n(crst_n), .d(tog_q), .q(tog_s)
    );

    // processor domain: a toggle change is one arrival; set beats clear
    always_ff @(posedge cclk or negedge crst_n) begin
      if (!crst_n) begin
        tog_d <= 1'b0;
        irq_q <= 1'b0;
      end else begin
        tog_d <= tog_s;
        irq_q <= arrive[g] | (irq_q & ~clr_here);
      end
    end

    assign clr_here  = rd_en && rd_idx == MIW'(g);
    assign arrive[g] = tog_s ^ tog_d;
    assign irq[g]    = irq_q;
    assign box[g]    = word_q;
  end

  assign rd_data = box[rd_idx];
endmodule

// File: rtl/bififo_mbx.sv
module bififo_mbx
  import bf_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 4,
  parameter int NMB = 2,
  localparam int MIW = (NMB > 1) ? $clog2(NMB) : 1
) (
  input  logic           rst_n,
  input  logic           per_clk,
  input  logic           per_fifo_clr,
  input  logic           per_cs,
  input  logic           per_dir,
  input  logic           per_mbsel,
  input  logic [MIW-1:0] per_mbidx,
  input  logic [DW-1:0]  per_din,
  output logic [DW-1:0]  per_dout,
  output logic           per_oe,
  output logic           per_in_full,
  output logic           per_in_afull,
  output logic           per_in_aempty,
  output logic           per_out_empty,
  output logic           per_out_aempty,
  output logic           per_out_afull,
  input  logic           cpu_clk,
  input  logic [AW:0]    cfg_afull,
  input  logic [AW:0]    cfg_aempty,
  input  logic           cpu_wr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic           cpu_out_full,
  output logic           cpu_out_afull,
  output logic           cpu_out_aempty,
  input  logic           cpu_rd,
  output logic [DW-1:0]  cpu_rdata,
  output logic           cpu_in_empty,
  output logic           cpu_in_afull,
  output logic           cpu_in_aempty,
  input  logic [1:0]     irq_en,
  input  logic           cpu_mb_rd,
  input  logic [MIW-1:0] cpu_mb_idx,
  output logic [DW-1:0]  cpu_mb_data,
  output logic [NMB-1:0] mb_irq,
  output logic           cpu_irq
);
  // reset tree: global reset per domain, FIFO reset also taken by the clear
  logic fifo_arst_n, per_grst_n, per_frst_n, cpu_grst_n, cpu_frst_n;
  assign fifo_arst_n = rst_n & ~per_fifo_clr;

  bf_rst_sync u_rs_pg (.clk(per_clk), .arst_n(rst_n),       .srst_n(per_grst_n));
  bf_rst_sync u_rs_pf (.clk(per_clk), .arst_n(fifo_arst_n), .srst_n(per_frst_n));
  bf_rst_sync u_rs_cg (.clk(cpu_clk), .arst_n(rst_n),       .srst_n(cpu_grst_n));
  bf_rst_sync u_rs_cf (.clk(cpu_clk), .arst_n(fifo_arst_n), .srst_n(cpu_frst_n));

  // peripheral request decode
  logic per_in_req, per_out_req, per_mb_req;
  assign per_in_req  = per_cs &  per_dir & ~per_mbsel;
  assign per_out_req = per_cs & ~per_dir & ~per_mbsel;
  assign per_mb_req  = per_cs &  per_dir &  per_mbsel;
  assign per_oe      = per_out_req;

  // named state for the checker
  logic [AW:0]    in_wptr, in_rptr, out_wptr, out_rptr;
  logic [NMB-1:0] mb_arrive;
  wside_t in_wf, out_wf;
  rside_t in_rf, out_rf;

  bf_async_fifo #(.DW(DW), .AW(AW)) u_in_fifo (
    .wclk(per_clk), .wrst_n(per_frst_n), .wr_en(per_in_req), .wdata(per_din),
    .rclk(cpu_clk), .rrst_n(cpu_frst_n), .rd_en(cpu_rd), .rdata(cpu_rdata),
    .lvl_af(cfg_afull), .lvl_ae(cfg_aempty),
    .wflg(in_wf), .rflg(in_rf), .wptr_o(in_wptr), .rptr_o(in_rptr)
  );

  bf_async_fifo #(.DW(DW), .AW(AW)) u_out_fifo (
    .wclk(cpu_clk), .wrst_n(cpu_frst_n), .wr_en(cpu_wr), .wdata(cpu_wdata),
    .rclk(per_clk), .rrst_n(per_frst_n), .rd_en(per_out_req), .rdata(per_dout),
    .lvl_af(cfg_afull), .lvl_ae(cfg_aempty),
    .wflg(out_wf), .rflg(out_rf), .wptr_o(out_wptr), .rptr_o(out_rptr)
  );

  bf_mbox #(.DW(DW), .NMB(NMB), .MIW(MIW)) u_mbox (
    .pclk(per_clk), .prst_n(per_grst_n), .wr_en(per_mb_req),
    .wr_idx(per_mbidx), .wr_data(per_din),
    .cclk(cpu_clk), .crst_n(cpu_grst_n), .rd_en(cpu_mb_rd),
    .rd_idx(cpu_mb_idx), .rd_data(cpu_mb_data),
    .irq(mb_irq), .arrive(mb_arrive)
  );

  assign per_in_full    = in_wf.full;
  assign per_in_afull   = in_wf.afull;
  assign per_in_aempty  = in_wf.aempty;
  assign per_out_empty  = out_rf.empty;
  assign per_out_aempty = out_rf.aempty;
  assign per_out_afull  = out_rf.afull;

  assign cpu_in_empty   = in_rf.empty;
  assign cpu_in_afull   = in_rf.afull;
  assign cpu_in_aempty  = in_rf.aempty;
  assign cpu_out_full   = out_wf.full;
  assign cpu_out_afull  = out_wf.afull;
  assign cpu_out_aempty = out_wf.aempty;

  assign cpu_irq = (|mb_irq) | (irq_en[0] & in_rf.afull) | (irq_en[1] & out_wf.aempty);
endmodule

// File: rtl/bf_chk.sv
module bf_chk #(
  parameter int AW  = 4,
  parameter int NMB = 2,
  parameter int MIW = 1
) (
  input logic           per_clk,
  input logic           cpu_clk,
  input logic           per_frst_n,
  input logic           cpu_frst_n,
  input logic           cpu_grst_n,
  input logic           per_cs,
  input logic           per_dir,
  input logic           per_mbsel,
  input logic           per_in_full,
  input logic           per_in_afull,
  input logic           per_out_empty,
  input logic           per_out_aempty,
  input logic           cpu_wr,
  input logic           cpu_out_full,
  input logic           cpu_rd,
  input logic           cpu_in_empty,
  input logic           cpu_mb_rd,
  input logic [MIW-1:0] cpu_mb_idx,
  input logic [NMB-1:0] mb_irq,
  input logic [NMB-1:0] mb_arrive,
  input logic [AW:0]    in_wptr,
  input logic [AW:0]    in_rptr,
  input logic [AW:0]    out_wptr,
  input logic [AW:0]    out_rptr
);
  // R3: push into full inbound leaves the write pointer where it was
  p_no_overflow_r3: assert property (@(posedge per_clk) disable iff (!per_frst_n)
    (per_cs && per_dir && !per_mbsel && per_in_full) |=> $stable(in_wptr));

  // R3: pop from empty outbound at the peripheral port
  p_no_underflow_per_r3: assert property (@(posedge per_clk) disable iff (!per_frst_n)
    (per_cs && !per_dir && !per_mbsel && per_out_empty) |=> $stable(out_rptr));

  // R3: processor-side overflow and underflow
  p_no_overflow_cpu_r3: assert property (@(posedge cpu_clk) disable iff (!cpu_frst_n)
    (cpu_wr && cpu_out_full) |=> $stable(out_wptr));
  p_no_underflow_cpu_r3: assert property (@(posedge cpu_clk) disable iff (!cpu_frst_n)
    (cpu_rd && cpu_in_empty) |=> $stable(in_rptr));

  // R4: no chip select, no pointer movement on the peripheral side
  p_cs_idle_r4: assert property (@(posedge per_clk) disable iff (!per_frst_n)
    !per_cs |=> ($stable(in_wptr) && $stable(out_rptr)));

  // R5: full lies inside almost-full
  p_full_in_afull_r5: assert property (@(posedge per_clk) disable iff (!per_frst_n)
    per_in_full |-> per_in_afull);

  // R6: empty lies inside almost-empty
  p_empty_in_aempty_r6: assert property (@(posedge per_clk) disable iff (!per_frst_n)
    per_out_empty |-> per_out_aempty);

  // R9: mailbox traffic never moves a FIFO pointer
  p_mbox_no_fifo_r9: assert property (@(posedge per_clk) disable iff (!per_frst_n)
    (per_cs && per_mbsel) |=> ($stable(in_wptr) && $stable(out_rptr)));

  for (genvar i = 0; i < NMB; i++) begin : g_mb
    // R10: reading a mailbox with no arrival clears its interrupt
    p_mb_clear_r10: assert property (@(posedge cpu_clk) disable iff (!cpu_grst_n)
      (cpu_mb_rd && cpu_mb_idx == MIW'(i) && !mb_arrive[i]) |=> !mb_irq[i]);
    // R10: reading another mailbox keeps this interrupt
    p_mb_keep_r10: assert property (@(posedge cpu_clk) disable iff (!cpu_grst_n)
      (cpu_mb_rd && cpu_mb_idx != MIW'(i) && mb_irq[i]) |=> mb_irq[i]);
    // R11: an arrival always sets the interrupt, even against a read
    p_mb_set_r11: assert property (@(posedge cpu_clk) disable iff (!cpu_grst_n)
      mb_arrive[i] |=> mb_irq[i]);
  end
endmodule

bind bififo_mbx bf_chk #(.AW(AW), .NMB(NMB), .MIW(MIW)) u_chk (
  .per_clk(per_clk), .cpu_clk(cpu_clk),
  .per_frst_n(per_frst_n), .cpu_frst_n(cpu_frst_n), .cpu_grst_n(cpu_grst_n),
  .per_cs(per_cs), .per_dir(per_dir), .per_mbsel(per_mbsel),
  .per_in_full(per_in_full), .per_in_afull(per_in_afull),
  .per_out_empty(per_out_empty), .per_out_aempty(per_out_aempty),
  .cpu_wr(cpu_wr), .cpu_out_full(cpu_out_full),
  .cpu_rd(cpu_rd), .cpu_in_empty(cpu_in_empty),
  .cpu_mb_rd(cpu_mb_rd), .cpu_mb_idx(cpu_mb_idx),
  .mb_irq(mb_irq), .mb_arrive(mb_arrive),
  .in_wptr(in_wptr), .in_rptr(in_rptr), .out_wptr(out_wptr), .out_rptr(out_rptr)
);

// File: tb/sim_bififo_mbx.sv
module sim_bififo_mbx;
  localparam int DEPTH = 16;
  localparam int AFL   = 12;
  localparam int AEL   = 3;

  logic        rst_n = 1'b0, per_clk = 1'b0, cpu_clk = 1'b0;
  logic        per_fifo_clr = 1'b0, per_cs = 1'b0, per_dir = 1'b0, per_mbsel = 1'b0;
  logic        per_mbidx = 1'b0;
  logic [31:0] per_din = '0, cpu_wdata = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_mb_rd = 1'b0, cpu_mb_idx = 1'b0;
  logic [1:0]  irq_en = 2'b00;
  logic [4:0]  cfg_afull = 5'(AFL), cfg_aempty = 5'(AEL);
  logic [31:0] per_dout, cpu_rdata, cpu_mb_data;
  logic        per_oe, per_in_full, per_in_afull, per_in_aempty;
  logic        per_out_empty, per_out_aempty, per_out_afull;
  logic        cpu_out_full, cpu_out_afull, cpu_out_aempty;
  logic        cpu_in_empty, cpu_in_afull, cpu_in_aempty, cpu_irq;
  logic [1:0]  mb_irq;

  int nchk = 0, nerr = 0;
  logic done = 1'b0, mon_en = 1'b0, seen0 = 1'b0;

  bififo_mbx u0 (
    .rst_n(rst_n), .per_clk(per_clk), .per_fifo_clr(per_fifo_clr),
    .per_cs(per_cs), .per_dir(per_dir), .per_mbsel(per_mbsel),
    .per_mbidx(per_mbidx), .per_din(per_din), .per_dout(per_dout),
    .per_oe(per_oe), .per_in_full(per_in_full), .per_in_afull(per_in_afull),
    .per_in_aempty(per_in_aempty), .per_out_empty(per_out_empty),
    .per_out_aempty(per_out_aempty), .per_out_afull(per_out_afull),
    .cpu_clk(cpu_clk), .cfg_afull(cfg_afull), .cfg_aempty(cfg_aempty),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_out_full(cpu_out_full),
    .cpu_out_afull(cpu_out_afull), .cpu_out_aempty(cpu_out_aempty),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_in_empty(cpu_in_empty),
    .cpu_in_afull(cpu_in_afull), .cpu_in_aempty(cpu_in_aempty),
    .irq_en(irq_en), .cpu_mb_rd(cpu_mb_rd), .cpu_mb_idx(cpu_mb_idx),
    .cpu_mb_data(cpu_mb_data), .mb_irq(mb_irq), .cpu_irq(cpu_irq)
  );

  always #10 cpu_clk = ~cpu_clk;   // 50 MHz
  always #7  per_clk = ~per_clk;   // unrelated peripheral clock

  always @(negedge cpu_clk) if (mon_en && mb_irq[0]) seen0 = 1'b1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge cpu_clk);
    repeat (6) @(negedge per_clk);
  endtask

  task automatic per_push(input logic [31:0] w);
    @(negedge per_clk);
    per_cs = 1'b1; per_dir = 1'b1; per_mbsel = 1'b0; per_din = w;
    @(negedge per_clk);
    per_cs = 1'b0;
  endtask

  task automatic per_pop(output logic [31:0] w, output logic oe);
    @(negedge per_clk);
    w = per_dout;
    per_cs = 1'b1; per_dir = 1'b0; per_mbsel = 1'b0;
    #1 oe = per_oe;
    @(negedge per_clk);
    per_cs = 1'b0;
  endtask

  task automatic mb_write(input logic idx, input logic [31:0] w);
    @(negedge per_clk);
    per_cs = 1'b1; per_dir = 1'b1; per_mbsel = 1'b1; per_mbidx = idx; per_din = w;
    @(negedge per_clk);
    per_cs = 1'b0; per_mbsel = 1'b0;
  endtask

  task automatic cpu_push(input logic [31:0] w);
    @(negedge cpu_clk);
    cpu_wr = 1'b1; cpu_wdata = w;
    @(negedge cpu_clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_pop(output logic [31:0] w);
    @(negedge cpu_clk);
    w = cpu_rdata;
    cpu_rd = 1'b1;
    @(negedge cpu_clk);
    cpu_rd = 1'b0;
  endtask

  task automatic cpu_mb_read(input logic idx, output logic [31:0] w);
    @(negedge cpu_clk);
    cpu_mb_idx = idx;
    #1 w = cpu_mb_data;
    cpu_mb_rd = 1'b1;
    @(negedge cpu_clk);
    cpu_mb_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 per_in_full", 32'(per_in_full), 0);
    chk("R12 per_in_aempty", 32'(per_in_aempty), 1);
    chk("R12 per_out_empty", 32'(per_out_empty), 1);
    chk("R12 cpu_in_empty", 32'(cpu_in_empty), 1);
    chk("R12 per_oe", 32'(per_oe), 0);
    chk("R12 mb_irq", 32'(mb_irq), 0);
  endtask

  task automatic t_inbound();
    logic [31:0] pat [5] = '{32'hFFFF_FFFF, 32'h0, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h1};
    logic [31:0] w;
    for (int i = 0; i < 5; i++) begin
      per_push(pat[i]);
      chk("R5 aempty after push", 32'(per_in_aempty), 32'((i + 1) <= AEL));
    end
    settle();
    chk("R1 not empty", 32'(cpu_in_empty), 0);
    for (int i = 0; i < 5; i++) begin
      cpu_pop(w);
      chk("R1 inbound order", w, pat[i]);
    end
    settle();
    chk("R1 drained", 32'(cpu_in_empty), 1);
  endtask

  task automatic t_full();
    logic [31:0] w;
    for (int i = 0; i < DEPTH + 2; i++) begin
      int k;
      per_push(32'h100 + 32'(i));
      k = (i + 1 > DEPTH) ? DEPTH : i + 1;
      chk("R5 per_in_full", 32'(per_in_full), 32'(k >= DEPTH));
      chk("R5 per_in_afull", 32'(per_in_afull), 32'(k >= AFL));
    end
    settle();
    chk("R7 cpu_in_afull", 32'(cpu_in_afull), 1);
    chk("R7 cpu_in_aempty", 32'(cpu_in_aempty), 0);
    for (int i = 0; i < DEPTH; i++) begin
      cpu_pop(w);
      chk("R3 full drop keeps data", w, 32'h100 + 32'(i));
    end
    settle();
    chk("R3 empty after drain", 32'(cpu_in_empty), 1);
    cpu_pop(w);                  // pop while empty: must be ignored
    per_push(32'h0000_ABCD);
    settle();
    cpu_pop(w);
    chk("R3 empty pop ignored", w, 32'h0000_ABCD);
    settle();
    chk("R3 empty again", 32'(cpu_in_empty), 1);
  endtask

  task automatic t_outbound();
    logic [31:0] w;
    logic oe;
    for (int i = 0; i < DEPTH; i++) begin
      cpu_push(32'h200 + 32'(i));
      chk("R7 cpu_out_full", 32'(cpu_out_full), 32'(i + 1 >= DEPTH));
    end
    cpu_push(32'hDEAD_0000);    // into full: dropped
    settle();
    chk("R6 per_out_empty", 32'(per_out_empty), 0);
    chk("R6 per_out_afull", 32'(per_out_afull), 1);
    chk("R6 per_out_aempty", 32'(per_out_aempty), 0);
    for (int i = 0; i < DEPTH; i++) begin
      int r;
      per_pop(w, oe);
      r = DEPTH - 1 - i;
      chk("R2 outbound order", w, 32'h200 + 32'(i));
      chk("R2 per_oe", 32'(oe), 1);
      chk("R6 aempty", 32'(per_out_aempty), 32'(r <= AEL));
      chk("R6 afull", 32'(per_out_afull), 32'(r >= AFL));
      chk("R6 empty", 32'(per_out_empty), 32'(r == 0));
    end
    settle();
    chk("R7 cpu_out_aempty", 32'(cpu_out_aempty), 1);
    chk("R7 cpu_out_afull", 32'(cpu_out_afull), 0);
  endtask

  task automatic t_cs_idle();
    logic [31:0] w;
    logic oe;
    for (int i = 0; i < 4; i++) begin
      @(negedge per_clk);
      per_cs = 1'b0; per_dir = 1'b1; per_din = 32'h3C00 + 32'(i);
    end
    settle();
    chk("R4 no push without cs", 32'(cpu_in_empty), 1);
    cpu_push(32'h0000_0777);
    settle();
    for (int i = 0; i < 4; i++) begin
      @(negedge per_clk);
      per_cs = 1'b0; per_dir = 1'b0;
      #1 chk("R2 oe low without cs", 32'(per_oe), 0);
    end
    settle();
    chk("R4 no pop without cs", 32'(per_out_empty), 0);
    per_pop(w, oe);
    chk("R4 word kept", w, 32'h0000_0777);
  endtask

  task automatic t_irq_clear();
    logic [31:0] w;
    for (int i = 0; i < AFL; i++) per_push(32'h400 + 32'(i));
    settle();
    irq_en = 2'b01;
    #1 chk("R7 irq from inbound afull", 32'(cpu_irq), 1);
    irq_en = 2'b00;
    #1 chk("R7 irq masked", 32'(cpu_irq), 0);
    irq_en = 2'b10;
    #1 chk("R7 irq from outbound aempty", 32'(cpu_irq), 1);
    irq_en = 2'b00;
    for (int i = 0; i < 3; i++) cpu_push(32'h500 + 32'(i));
    mb_write(1'b0, 32'h0000_1234);
    settle();
    chk("R8 outbound loaded", 32'(per_out_empty), 0);
    @(negedge per_clk);
    per_fifo_clr = 1'b1;
    repeat (2) @(negedge per_clk);
    per_fifo_clr = 1'b0;
    settle();
    chk("R8 inbound empty cpu", 32'(cpu_in_empty), 1);
    chk("R8 inbound afull low", 32'(per_in_afull), 0);
    chk("R8 inbound aempty", 32'(per_in_aempty), 1);
    chk("R8 outbound empty", 32'(per_out_empty), 1);
    chk("R8 outbound aempty cpu", 32'(cpu_out_aempty), 1);
    chk("R8 mailbox irq kept", 32'(mb_irq), 32'b01);
    cpu_mb_read(1'b0, w);
    chk("R8 mailbox data kept", w, 32'h0000_1234);
    per_push(32'h0000_0055);
    settle();
    cpu_pop(w);
    chk("R8 fifo usable after clear", w, 32'h0000_0055);
    settle();
  endtask

  task automatic t_mailbox();
    logic [31:0] w;
    chk("R10 irq clear after read", 32'(mb_irq), 0);
    mb_write(1'b1, 32'hB1B1_0001);
    settle();
    chk("R9 mbox1 irq", 32'(mb_irq), 32'b10);
    chk("R9 no fifo entry", 32'(cpu_in_empty), 1);
    mb_write(1'b0, 32'hB0B0_0000);
    settle();
    chk("R9 both irq", 32'(mb_irq), 32'b11);
    cpu_mb_read(1'b0, w);
    chk("R10 mbox0 data", w, 32'hB0B0_0000);
    @(negedge cpu_clk);
    chk("R10 only mbox0 cleared", 32'(mb_irq), 32'b10);
    cpu_mb_read(1'b1, w);
    chk("R10 mbox1 data", w, 32'hB1B1_0001);
    @(negedge cpu_clk);
    chk("R10 mbox1 cleared", 32'(mb_irq), 32'b00);
  endtask

  task automatic t_collide();
    @(negedge cpu_clk);
    cpu_mb_idx = 1'b0; cpu_mb_rd = 1'b1; seen0 = 1'b0; mon_en = 1'b1;
    mb_write(1'b0, 32'h00C0_FFEE);
    repeat (8) @(negedge cpu_clk);
    cpu_mb_rd = 1'b0; mon_en = 1'b0;
    @(negedge cpu_clk);
    chk("R11 set wins over read", 32'(seen0), 1);
    chk("R11 cleared by held read", 32'(mb_irq[0]), 0);
    #1 chk("R11 new word stored", cpu_mb_data, 32'h00C0_FFEE);
  endtask

  initial begin
    repeat (4) @(negedge cpu_clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_inbound();
    t_full();
    t_outbound();
    t_cs_idle();
    t_irq_clear();
    t_mailbox();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule